// File: doc/BRIEF.md
# Half to Single Precision Widener

This block takes a 16-bit half-precision floating-point word and returns the 32-bit single-precision word that holds the same value. A finite half value always fits exactly in single precision, so the block needs no rounding. It never raises inexact, overflow or underflow. The only exception it reports is invalid, for a signalling NaN.

A mode input picks how the top exponent code of the half word is read. In IEEE mode, that code encodes infinity and NaN. In the alternative format there are no special codes, so the top exponent is just one more binade of normal numbers. A second input selects default-NaN behaviour. When it is set, every NaN result is replaced by one fixed canonical NaN.

The block has one register stage. A word presented with `in_valid` high appears on the outputs on the next clock edge, with `out_valid` high. All parameter defaults describe the standard 16-bit and 32-bit layouts.

Top module: `h2s_widen`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low after each cycle in which it is low. While `in_valid` is low, `out_single` keeps its last value.
- R2: A normal input converts as follows. The exponent field is 1..30, and in alternative mode it may also be 31. The sign is kept. The output exponent is the input exponent plus 112 (0x70). The output fraction is the 10-bit input fraction in bits 22:13 of the output, with zeros below.
- R3: A subnormal input converts to an exact normal single. A subnormal has exponent field 0 and a nonzero fraction. Let z be the number of leading zeros of the 10-bit fraction. The output exponent is 112 - z. The output fraction is the input fraction shifted left by z+1, with its top bit dropped, in bits 22:13.
- R4: An input with exponent field 0 and fraction 0 gives a zero with the same sign (0x00000000 or 0x80000000).
- R5: In IEEE mode, exponent field 31 with fraction 0 gives an infinity with the input sign: exponent 0xFF, fraction 0.
- R6: In alternative mode, exponent field 31 is an ordinary normal exponent. It gives output exponent 143 (0x8F) and never gives an infinity or a NaN.
- R7: In IEEE mode with default-NaN mode off, a NaN input gives a NaN. A NaN input has exponent field 31 and a nonzero fraction. The result has the input sign, exponent 0xFF, bit 22 (the quiet bit) set, and input fraction bits 8:0 in output bits 21:13.
- R8: In IEEE mode, a signalling NaN sets `out_invalid` for its output cycle. A signalling NaN has exponent 31, fraction bit 9 clear and a nonzero fraction. A quiet NaN, with fraction bit 9 set, does not set `out_invalid`.
- R9: In IEEE mode with default-NaN mode on, every NaN input gives 0x7FC00000. The invalid rule of R8 still applies.
- R10: `out_invalid` is never set in alternative mode or for a non-NaN input. After reset, `out_valid`, `out_single` and `out_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_half | input | 16 | Half-precision operand |
| alt_mode | input | 1 | 1: alternative half format without special codes; 0: IEEE half |
| dn_mode | input | 1 | 1: NaN results become the default NaN |
| out_valid | output | 1 | Result valid, one cycle after the input |
| out_single | output | 32 | Single-precision result |
| out_invalid | output | 1 | Invalid exception for the result in this cycle |

## Verification
The bench builds the block with its default parameters: a 5-bit exponent and 10-bit fraction in, and an 8-bit exponent and 23-bit fraction out. At these sizes the whole input space, 65536 words, can be streamed through in each mode at one word per cycle. Every subnormal shift distance, both signs, and every NaN payload in both the quiet and the signalling form are therefore compared against a reference model. A separate pass repeats all NaN words with default-NaN mode on. Directed tasks cover the reset state and the holding of the output while the valid input is low.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } val_class_e;
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
#(
  parameter int HE = 5,
  parameter int HF = 10
) (
  input  logic [HE-1:0] exp_i,
  input  logic [HF-1:0] frac_i,
  input  logic          alt_i,
  output val_class_e    cls_o,
  output logic          snan_o
);
  logic exp_zero, exp_top, frac_zero;

  assign exp_zero  = (exp_i == '0);
  assign exp_top   = (exp_i == '1);
  assign frac_zero = (frac_i == '0);

  always_comb begin
    if (exp_zero)
      cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_top && !alt_i)
      cls_o = frac_zero ? CLS_INF : CLS_NAN;
    else
      cls_o = CLS_NORM;
  end

  // quiet bit is the fraction MSB; clear with nonzero payload means signalling
  assign snan_o = (cls_o == CLS_NAN) && !frac_i[HF-1];
endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W  = 10,
  localparam int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [LW-1:0] cnt_o
);
  always_comb begin
    logic hit;
    hit   = 1'b0;
    cnt_o = LW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && vec_i[i]) begin
        hit   = 1'b1;
        cnt_o = LW'(W - 1 - i);
      end
    end
  end
endmodule

// File: rtl/h2s_pack.sv
module h2s_pack
  import h2s_pkg::*;
#(
  parameter int HE = 5,
  parameter int HF = 10,
  parameter int SE = 8,
  parameter int SF = 23,
  localparam int LW = $clog2(HF + 1),
  localparam int SW = 1 + SE + SF,
  localparam int PAD = SF - HF,
  localparam int BIAS_GAP = (1 << (SE - 1)) - (1 << (HE - 1))
) (
  input  val_class_e    cls_i,
  input  logic          sign_i,
  input  logic [HE-1:0] exp_i,
  input  logic [HF-1:0] frac_i,
  input  logic [LW-1:0] lz_i,
  input  logic          dn_i,
  output logic [SW-1:0] word_o
);
  localparam logic [SE-1:0] GAP_V   = SE'(BIAS_GAP);
  localparam logic [SW-1:0] DEF_NAN = {1'b0, {SE{1'b1}}, 1'b1, {(SF - 1){1'b0}}};

  logic [HF:0]   sub_shift;
  logic [SE-1:0] norm_exp, sub_exp;

  assign norm_exp  = SE'(exp_i) + GAP_V;
  assign sub_exp   = GAP_V - SE'(lz_i);
  assign sub_shift = ({1'b0, frac_i} << lz_i) << 1;

  always_comb begin
    unique case (cls_i)
      CLS_ZERO: word_o = {sign_i, {(SW - 1){1'b0}}};
      CLS_SUB:  word_o = {sign_i, sub_exp, sub_shift[HF-1:0], {PAD{1'b0}}};
      CLS_INF:  word_o = {sign_i, {SE{1'b1}}, {SF{1'b0}}};
      CLS_NAN:  word_o = dn_i ? DEF_NAN
                              : {sign_i, {SE{1'b1}}, 1'b1, frac_i[HF-2:0], {PAD{1'b0}}};
      default:  word_o = {sign_i, norm_exp, frac_i, {PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
#(
  parameter int HE = 5,
  parameter int HF = 10,
  parameter int SE = 8,
  parameter int SF = 23,
  localparam int HW = 1 + HE + HF,
  localparam int SW = 1 + SE + SF,
  localparam int LW = $clog2(HF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [HW-1:0] in_half,
  input  logic          alt_mode,
  input  logic          dn_mode,
  output logic          out_valid,
  output logic [SW-1:0] out_single,
  output logic          out_invalid
);
  localparam logic [SW-1:0] DEF_NAN = {1'b0, {SE{1'b1}}, 1'b1, {(SF - 1){1'b0}}};

  logic          h_sign;
  logic [HE-1:0] h_exp;
  logic [HF-1:0] h_frac;
  val_class_e    cls;
  logic          snan;
  logic [LW-1:0] lz;
  logic [SW-1:0] word;

  assign h_sign = in_half[HW-1];
  assign h_exp  = in_half[HW-2 -: HE];
  assign h_frac = in_half[HF-1:0];

  h2s_classify #(.HE(HE), .HF(HF)) i_classify (
    .exp_i (h_exp), .frac_i(h_frac), .alt_i(alt_mode),
    .cls_o (cls),   .snan_o(snan)
  );

  h2s_lzc #(.W(HF)) i_lzc (.vec_i(h_frac), .cnt_o(lz));

  h2s_pack #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) i_pack (
    .cls_i (cls),   .sign_i(h_sign), .exp_i(h_exp), .frac_i(h_frac),
    .lz_i  (lz),    .dn_i  (dn_mode), .word_o(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_single  <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid && snan;
      if (in_valid) out_single <= word;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R1
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_single)));  // R1
  AST_INVALID_IS_NAN: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (out_valid && out_single[SW-2 -: SE] == '1 && out_single[SF-1]));  // R8
  AST_ALT_NO_INVALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && alt_mode) |=> !out_invalid);  // R10
  AST_DEFAULT_NAN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dn_mode && !alt_mode && h_exp == '1 && h_frac != '0) |=> (out_single == DEF_NAN));  // R9
endmodule

// File: tb/test_h2s_widen.sv
module test_h2s_widen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic        alt_mode = 1'b0;
  logic        dn_mode = 1'b0;
  logic        out_valid;
  logic [31:0] out_single;
  logic        out_invalid;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  h2s_widen i_h2s_widen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .alt_mode(alt_mode), .dn_mode(dn_mode), .out_valid(out_valid),
    .out_single(out_single), .out_invalid(out_invalid)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Reference model written from the requirement text
  function automatic void ref_model(input logic [15:0] h, input logic alt, input logic dn,
                                    output logic [31:0] r, output logic inv, output string req);
    logic       s = h[15];
    logic [4:0] e = h[14:10];
    logic [9:0] f = h[9:0];
    inv = 1'b0;
    if (e == 5'd31 && !alt) begin
      if (f == 0) begin
        r = {s, 8'hFF, 23'h0}; req = "R5";
      end else begin
        inv = !f[9];  // R8
        if (dn) begin r = 32'h7FC0_0000; req = "R9"; end
        else begin r = {s, 8'hFF, 1'b1, f[8:0], 13'h0}; req = inv ? "R8" : "R7"; end
      end
    end else if (e == 0) begin
      if (f == 0) begin
        r = {s, 31'h0}; req = "R4";
      end else begin
        int ex = -14;
        logic [10:0] m = {1'b0, f};
        while (!m[10]) begin m = m << 1; ex--; end
        r = {s, 8'(ex + 127), m[9:0], 13'h0}; req = "R3";
      end
    end else begin
      r = {s, 8'(int'(e) + 112), f, 13'h0};
      req = (e == 5'd31) ? "R6" : "R2";
    end
  endfunction

  task automatic task_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "reset out_valid", {31'h0, out_valid}, 32'h0);
    check("R10", "reset out_single", out_single, 32'h0);
    check("R10", "reset out_invalid", {31'h0, out_invalid}, 32'h0);
    rst = 1'b0;
  endtask

  // Streams words at one per cycle; each output is checked one cycle later
  task automatic task_sweep(input logic alt, input logic dn, input bit nan_only);
    logic [31:0] pe = '0;
    logic        pi = 1'b0;
    string       pr = "";
    bit          have = 1'b0;
    alt_mode = alt;
    dn_mode  = dn;
    for (int k = 0; k < 65536; k++) begin
      logic [15:0] h = 16'(k);
      if (nan_only && !(h[14:10] == 5'd31 && h[9:0] != 0)) continue;
      @(negedge clk);
      if (have) begin
        check("R1", "out_valid", {31'h0, out_valid}, 32'h1);
        check(pr, "out_single", out_single, pe);
        check((pi || alt) ? "R8" : "R10", "out_invalid", {31'h0, out_invalid}, {31'h0, pi});
      end
      in_valid = 1'b1;
      in_half  = h;
      ref_model(h, alt, dn, pe, pi, pr);
      have = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (have) begin
      check(pr, "out_single last", out_single, pe);
      check("R8", "out_invalid last", {31'h0, out_invalid}, {31'h0, pi});
    end
  endtask

  // R1: output holds and out_valid drops while in_valid is low
  task automatic task_hold;
    logic [31:0] e;
    logic        i;
    string       r;
    alt_mode = 1'b0;
    dn_mode  = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = 16'hC500;  // -5.0
    ref_model(16'hC500, 1'b0, 1'b0, e, i, r);
    @(negedge clk);
    in_valid = 1'b0;
    in_half  = 16'h7D00;  // signalling NaN, must not reach the output
    check("R2", "captured value", out_single, e);
    repeat (3) begin
      @(negedge clk);
      check("R1", "held out_single", out_single, e);
      check("R1", "idle out_valid", {31'h0, out_valid}, 32'h0);
      check("R1", "idle out_invalid", {31'h0, out_invalid}, 32'h0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_errs++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    task_reset();
    task_hold();
    task_sweep(1'b0, 1'b0, 1'b0);  // IEEE: R2 R3 R4 R5 R7 R8
    task_sweep(1'b1, 1'b0, 1'b0);  // alternative: R6 R10
    task_sweep(1'b0, 1'b1, 1'b1);  // default NaN: R9
    task_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule